// File: doc/BRIEF.md
# Serial Chain-ID Decrementing Pass-Through

This block sits on the controller side of a serially addressed input device that can be chained with identical devices on one serial bus. The serial data input is copied to a downstream data output that feeds the next device in the chain. Each packet is three bytes long. Only the first byte, the control byte, is altered: its four-bit chain-ID field is reduced by one while the bits stream through. A device that receives an ID of zero is therefore the one being addressed, and each later device sees its distance from that device.

The chain-ID sits in the low nibble of the control byte in reversed bit order. Its least significant bit is sent first, so the subtraction can be done one bit at a time. A borrow flag starts at one and stays at one only while the incoming ID bits are zero. Each forwarded ID bit is the incoming bit XOR the borrow. The data path from input to output is purely combinational, so the downstream device sees no added clock latency.

The packet state machine in front of this block marks the control byte with a level input. The block counts bit positions on rising serial-clock edges. A deselect returns the bit position to the start of a byte.

Top module: `chain_id_forwarder`

## Requirements
- R1: While `ctrl_byte` is low (address and data bytes), `sdo` equals `mosi` in every bit period.
- R2: In the control byte, the first four bits sent (byte bits 7..4, most significant bit first) are forwarded unchanged.
- R3: In the control byte, byte bits 3..0 hold the chain-ID with ID bit 0 at byte bit 3 and ID bit 3 at byte bit 0. The forwarded ID is the incoming ID minus one, modulo 16.
- R4: An incoming chain-ID of 0000 is forwarded as 1111.
- R5: The output has no clock latency. The forwarded bit for a bit period depends on `mosi` in that same period.
- R6: Within the ID field, each forwarded bit is the incoming bit inverted when every earlier ID bit of that byte was 0, and unchanged otherwise. The first ID bit sent is always inverted.
- R7: Taking `nss` high returns the bit position to the first bit of a byte. A control byte cut short by a deselect does not disturb the decrement of the next full control byte.
- R8: After reset, and whenever `nss` is high, `sdo` equals `mosi`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| nss | input | 1 | Active-low device select; high clears the bit position |
| mosi | input | 1 | Serial data from the upstream side, most significant bit first |
| ctrl_byte | input | 1 | High for the whole control byte, from the packet state machine |
| sdo | output | 1 | Forwarded serial data for the next device in the chain |

## Verification
On every rising clock edge the bound checker confirms four things. Non-control bits and idle periods pass through unchanged. The upper nibble of the control byte is untouched. The first ID bit is inverted, and each later ID bit follows the running all-zero-so-far condition, tracked by a position counter kept inside the checker. A few behaviours only appear over a whole byte, and only the bench scenarios show them: the ID arithmetic over all sixteen values, including the wrap from 0000 to 1111; the zero-latency alignment of the forwarded byte; and recovery after a control byte cut short by a deselect.

// File: rtl/chain_id_forwarder.sv
module chain_id_forwarder #(
  parameter int BYTE_BITS = 8,
  parameter int ID_BITS   = 4
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic nss,
  input  logic mosi,
  input  logic ctrl_byte,
  output logic sdo
);
  localparam int PW       = $clog2(BYTE_BITS);
  localparam int ID_FIRST = BYTE_BITS - ID_BITS;

  logic [PW-1:0] pos;
  logic          borrow;

  wire clr_n = rst_n & ~nss;
  wire last  = (pos == PW'(BYTE_BITS - 1));
  wire in_id = ctrl_byte & (pos >= PW'(ID_FIRST));

  // borrow survives only across zero ID bits; it is re-armed at each byte end
  always_ff @(posedge sclk or negedge clr_n) begin
    if (!clr_n) begin
      pos    <= '0;
      borrow <= 1'b1;
    end else begin
      pos    <= last ? '0 : pos + 1'b1;
      borrow <= (in_id && !last) ? (borrow & ~mosi) : 1'b1;
    end
  end

  assign sdo = mosi ^ (in_id & borrow);
endmodule

// File: rtl/chain_id_forwarder_chk.sv
module chain_id_forwarder_chk #(
  parameter int BYTE_BITS = 8,
  parameter int ID_BITS   = 4
) (
  input logic sclk,
  input logic rst_n,
  input logic nss,
  input logic mosi,
  input logic ctrl_byte,
  input logic sdo
);
  localparam int PW       = $clog2(BYTE_BITS);
  localparam int ID_FIRST = BYTE_BITS - ID_BITS;

  logic [PW-1:0] cpos;
  logic          zeros;
  wire           cclr_n = rst_n & ~nss;

  always_ff @(posedge sclk or negedge cclr_n) begin
    if (!cclr_n) begin
      cpos  <= '0;
      zeros <= 1'b1;
    end else begin
      cpos <= cpos + 1'b1;
      if (cpos == PW'(BYTE_BITS - 1))
        zeros <= 1'b1;
      else if (ctrl_byte && cpos >= PW'(ID_FIRST))
        zeros <= zeros & ~mosi;
    end
  end

  a_r1_data_pass: assert property (@(posedge sclk) disable iff (!rst_n)
    !ctrl_byte |-> (sdo == mosi));

  a_r2_upper_nibble_pass: assert property (@(posedge sclk) disable iff (!rst_n)
    (ctrl_byte && !nss && cpos < PW'(ID_FIRST)) |-> (sdo == mosi));

  a_r6_first_id_bit_flips: assert property (@(posedge sclk) disable iff (!rst_n)
    (ctrl_byte && !nss && cpos == PW'(ID_FIRST)) |-> (sdo == !mosi));

  a_r6_later_id_bits: assert property (@(posedge sclk) disable iff (!rst_n)
    (ctrl_byte && !nss && cpos > PW'(ID_FIRST)) |-> (sdo == (mosi ^ zeros)));

  a_r4_zero_id_wraps: assert property (@(posedge sclk) disable iff (!rst_n)
    (ctrl_byte && !nss && cpos == PW'(BYTE_BITS - 1) && zeros && !mosi) |-> sdo);

  a_r8_idle_pass: assert property (@(posedge sclk) disable iff (!rst_n)
    nss |-> (sdo == mosi));
endmodule

bind chain_id_forwarder chain_id_forwarder_chk #(
  .BYTE_BITS(BYTE_BITS),
  .ID_BITS(ID_BITS)
) u_chk (
  .sclk(sclk),
  .rst_n(rst_n),
  .nss(nss),
  .mosi(mosi),
  .ctrl_byte(ctrl_byte),
  .sdo(sdo)
);

// File: tb/tb_chain_id_forwarder.sv
`timescale 1ns/1ps
module tb_chain_id_forwarder;
  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic nss = 1'b1;
  logic mosi = 1'b0;
  logic ctrl_byte = 1'b0;
  logic sdo;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  always #2.5 sclk = ~sclk;

  chain_id_forwarder dut (
    .sclk(sclk), .rst_n(rst_n), .nss(nss), .mosi(mosi),
    .ctrl_byte(ctrl_byte), .sdo(sdo)
  );

  function automatic logic [7:0] exp_ctrl(input logic [7:0] b);
    logic [3:0] id, nid;
    id  = {b[0], b[1], b[2], b[3]};
    nid = id - 4'd1;
    return {b[7:4], nid[0], nid[1], nid[2], nid[3]};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic ctl, input int nbits,
                           output logic [7:0] fwd);
    fwd = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge sclk);
      nss = 1'b0; ctrl_byte = ctl; mosi = b[i];
      #1 fwd[i] = sdo;
    end
    @(negedge sclk);
    nss = 1'b1; ctrl_byte = 1'b0; mosi = 1'b0;
    @(negedge sclk);
  endtask

  task automatic t_reset_idle();
    @(negedge sclk);
    mosi = 1'b1; #1 check("R8 idle high", {7'd0, sdo}, 8'd1);
    @(negedge sclk);
    mosi = 1'b0; #1 check("R8 idle low", {7'd0, sdo}, 8'd0);
  endtask

  task automatic t_packet(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] f;
    send_byte(c, 1'b1, 8, f);
    check("R2 R3 R4 R6 control byte", f, exp_ctrl(c));
    send_byte(a, 1'b0, 8, f);
    check("R1 R5 address byte", f, a);
    send_byte(d, 1'b0, 8, f);
    check("R1 R5 data byte", f, d);
  endtask

  task automatic t_all_ids();
    for (int k = 0; k < 16; k++) begin
      logic [7:0] c;
      c = {4'(k * 5 + 3), 4'(k)};
      t_packet(c, 8'(k * 37 + 11), 8'(~(k * 19)));
    end
  endtask

  task automatic t_zero_id();
    logic [7:0] f;
    send_byte(8'b0100_0000, 1'b1, 8, f);
    check("R4 zero id forwarded as ones", f, 8'b0100_1111);
  endtask

  task automatic t_truncated();
    logic [7:0] f;
    send_byte(8'b0000_1010, 1'b1, 6, f);
    send_byte(8'b0000_1000, 1'b1, 8, f);
    check("R7 after truncated byte", f, 8'b0000_0000);
    t_packet(8'b1000_0011, 8'h02, 8'h5A);
  endtask

  task automatic t_ones();
    logic [7:0] f;
    send_byte(8'hFF, 1'b1, 8, f);
    check("R3 id 1111 becomes 0111", f, 8'hF7);
    send_byte(8'hFF, 1'b0, 8, f);
    check("R1 ones data byte", f, 8'hFF);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge sclk);
    check("R8 reset state", {7'd0, sdo}, 8'd0);
    rst_n = 1'b1;
    t_reset_idle();
    t_zero_id();
    t_all_ids();
    t_truncated();
    t_ones();
    t_reset_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule